// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Set-on-Less-Than

This block is a purely combinational integer arithmetic and logic unit built from a row of identical one-bit slices. Each slice can invert its two operand bits, then forms their AND, their OR and a full-adder sum, and a small multiplexer picks one of these or a "less" input as the slice's result bit. Carries ripple from the least significant slice to the most significant one. A single set wire runs back from the most significant slice's adder sum to the least significant slice's less input, which is how the set-on-less-than result is formed.

A four-bit control word selects the function. Bit 3 inverts operand A and bit 2 inverts operand B while also driving the carry into the lowest slice. Bits 1:0 pick the slice output. Add, subtract, AND, OR, NOR and set-on-less-than are the intended codes, and every other code follows the same field rules. Besides the result, the block reports a zero flag, the carry out of the top slice and a signed overflow flag. Because there is no data stream to hold, the block has no valid/ready handshake: every output is a plain function of the present inputs.

Top module: `bitsliced_alu`

## Requirements
- R1: Control 4'b0000 (AND) gives result = a & b.
- R2: Control 4'b0001 (OR) gives result = a | b.
- R3: Control 4'b0010 (add) gives result = (a + b) modulo 2^WIDTH.
- R4: Control 4'b0110 (subtract) gives result = (a - b) modulo 2^WIDTH, formed as a + ~b + 1.
- R5: Control 4'b0111 (set-on-less-than) gives a result whose bit 0 equals bit WIDTH-1 of (a - b) modulo 2^WIDTH and whose other bits are 0. No overflow correction is applied, so a = 0x7FFFFFFF, b = 0xFFFFFFFF yields 1.
- R6: Control 4'b1100 (NOR) gives result = ~(a | b).
- R7: For every control value, carry_out is bit WIDTH of ea + eb + c2 and overflow is set exactly when ea and eb have equal sign bits and bit WIDTH-1 of that sum differs from them. Here ea is a, inverted when control bit 3 is 1, eb is b, inverted when control bit 2 is 1, and c2 is control bit 2.
- R8: zero is 1 exactly when every result bit is 0.
- R9: All outputs are combinational and follow a change of inputs with no clock cycle of latency.
- R10: The control word is decoded as {invert A [3], invert B and carry-in [2], select [1:0]}. Select 0 gives ea & eb, 1 gives ea | eb, 2 gives the sum bits and 3 gives the set-on-less-than pattern of R5, taken from the sum of ea and eb. This holds for all 16 codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | Operand A |
| b_in | input | WIDTH | Operand B |
| ctl | input | 4 | {invert A, invert B / carry-in, select[1:0]} |
| result | output | WIDTH | Selected slice outputs |
| zero | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Carry out of the most significant slice |
| overflow | output | 1 | Signed overflow of the adder chain |

## Verification
Every result and flag is due in the same cycle as its inputs, because no register lies on any path. The bench drives a new operand pair and control word just after a rising edge and samples all four outputs one nanosecond later, still well before the next edge. A four-bit instance is swept over every operand pair and every control code. A 32-bit instance receives sign-boundary corner cases and pseudo-random pairs for each code, and both are compared against an arithmetic model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } alu_sel_e;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic     a_bit,
  input  logic     b_bit,
  input  logic     inv_a,
  input  logic     inv_b,
  input  logic     carry_in,
  input  logic     less,
  input  alu_sel_e sel,
  output logic     res_bit,
  output logic     sum_bit,
  output logic     carry_nxt
);
  logic a_e, b_e;

  assign a_e       = a_bit ^ inv_a;
  assign b_e       = b_bit ^ inv_b;
  assign sum_bit   = a_e ^ b_e ^ carry_in;
  assign carry_nxt = (a_e & b_e) | (a_e & carry_in) | (b_e & carry_in);

  always_comb begin
    unique case (sel)
      SEL_AND:  res_bit = a_e & b_e;
      SEL_OR:   res_bit = a_e | b_e;
      SEL_SUM:  res_bit = sum_bit;
      default:  res_bit = less;
    endcase
  end

  // Full-adder truth table checked as arithmetic
  always_comb begin
    AST_SLICE_ADD: assert ({carry_nxt, sum_bit} == 2'(a_e) + 2'(b_e) + 2'(carry_in))
      else $error("slice adder mismatch"); // R7
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] value,
  output logic             is_zero
);
  assign is_zero = ~(|value);
endmodule

// File: rtl/bitsliced_alu.sv
module bitsliced_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [3:0]       ctl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             carry_out,
  output logic             overflow
);
  localparam int MSB = WIDTH - 1;

  logic             inv_a, inv_b;
  alu_sel_e         sel;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum_vec;
  logic [WIDTH-1:0] less_vec;
  logic             set_wire;

  assign inv_a    = ctl[3];
  assign inv_b    = ctl[2];
  assign sel      = alu_sel_e'(ctl[1:0]);
  assign carry[0] = inv_b;
  assign set_wire = sum_vec[MSB];

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_slice
      if (i == 0) begin : g_lsb
        assign less_vec[i] = set_wire;
      end else begin : g_upper
        assign less_vec[i] = 1'b0;
      end
      alu_bit_slice u_slice (
        .a_bit    (a_in[i]),
        .b_bit    (b_in[i]),
        .inv_a    (inv_a),
        .inv_b    (inv_b),
        .carry_in (carry[i]),
        .less     (less_vec[i]),
        .sel      (sel),
        .res_bit  (result[i]),
        .sum_bit  (sum_vec[i]),
        .carry_nxt(carry[i+1])
      );
    end
  endgenerate

  assign carry_out = carry[WIDTH];
  assign overflow  = carry[MSB] ^ carry[WIDTH];

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .value  (result),
    .is_zero(zero)
  );

  // Checks against whole-word arithmetic
  logic [WIDTH-1:0] a_e, b_e;
  logic [WIDTH:0]   word_sum;
  assign a_e      = inv_a ? ~a_in : a_in;
  assign b_e      = inv_b ? ~b_in : b_in;
  assign word_sum = {1'b0, a_e} + {1'b0, b_e} + {{WIDTH{1'b0}}, inv_b};

  always_comb begin
    AST_ZERO_FLAG: assert (zero == (result == '0))
      else $error("zero flag mismatch"); // R8
    AST_CARRY_CHAIN: assert ({carry_out, sum_vec} == word_sum)
      else $error("ripple chain mismatch"); // R7
    AST_SIGNED_OVERFLOW: assert (overflow == ((a_e[MSB] == b_e[MSB]) && (word_sum[MSB] != a_e[MSB])))
      else $error("overflow mismatch"); // R7
    if (sel == SEL_LESS) begin
      AST_SLT_UPPER_CLEAR: assert (result[WIDTH-1:1] == '0 && result[0] == word_sum[MSB])
        else $error("set-on-less-than pattern wrong"); // R5
    end
  end
endmodule

// File: tb/tb_bitsliced_alu.sv
module tb_bitsliced_alu;
  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] a32, b32, r32;
  logic [3:0]  c32;
  logic        z32, co32, ov32;
  logic [3:0]  a4, b4, r4;
  logic [3:0]  c4;
  logic        z4, co4, ov4;

  bitsliced_alu #(.WIDTH(32)) dut (
    .a_in(a32), .b_in(b32), .ctl(c32),
    .result(r32), .zero(z32), .carry_out(co32), .overflow(ov32)
  );

  bitsliced_alu #(.WIDTH(4)) dut4 (
    .a_in(a4), .b_in(b4), .ctl(c4),
    .result(r4), .zero(z4), .carry_out(co4), .overflow(ov4)
  );

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R10";
    endcase
  endfunction

  // Arithmetic model, width w <= 32
  task automatic model(input int w, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] c, output logic [31:0] r,
                       output logic co, output logic ov, output logic z);
    logic [32:0] mask, s;
    logic [31:0] ae, be, sm;
    mask = (33'd1 << w) - 33'd1;
    ae = (c[3] ? ~a : a) & mask[31:0];
    be = (c[2] ? ~b : b) & mask[31:0];
    s  = {1'b0, ae} + {1'b0, be} + {32'd0, c[2]};
    sm = s[31:0] & mask[31:0];
    co = s[w];
    ov = (ae[w-1] == be[w-1]) && (sm[w-1] != ae[w-1]);
    case (c[1:0])
      2'd0: r = ae & be;
      2'd1: r = ae | be;
      2'd2: r = sm;
      default: r = {31'd0, sm[w-1]};
    endcase
    z = (r == 32'd0);
  endtask

  // Outputs sampled 1 ns after the drive edge: zero latency (R9)
  task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
    logic [31:0] er; logic eco, eov, ez;
    @(posedge clk);
    a32 = a; b32 = b; c32 = c;
    #1;
    model(32, a, b, c, er, eco, eov, ez);
    checks++;
    if (r32 !== er) begin
      errors++;
      $display("FAIL %s/R9 w32 a=%h b=%h ctl=%b result=%h expected=%h", tag_of(c), a, b, c, r32, er);
    end else if (co32 !== eco || ov32 !== eov) begin
      errors++;
      $display("FAIL R7 w32 a=%h b=%h ctl=%b co/ov=%b%b expected=%b%b", a, b, c, co32, ov32, eco, eov);
    end else if (z32 !== ez) begin
      errors++;
      $display("FAIL R8 w32 a=%h b=%h ctl=%b zero=%b expected=%b", a, b, c, z32, ez);
    end
  endtask

  task automatic apply4(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
    logic [31:0] er; logic eco, eov, ez;
    @(posedge clk);
    a4 = a; b4 = b; c4 = c;
    #1;
    model(4, {28'd0, a}, {28'd0, b}, c, er, eco, eov, ez);
    checks++;
    if ({28'd0, r4} !== er) begin
      errors++;
      $display("FAIL %s w4 a=%h b=%h ctl=%b result=%h expected=%h", tag_of(c), a, b, c, r4, er[3:0]);
    end else if (co4 !== eco || ov4 !== eov) begin
      errors++;
      $display("FAIL R7 w4 a=%h b=%h ctl=%b co/ov=%b%b expected=%b%b", a, b, c, co4, ov4, eco, eov);
    end else if (z4 !== ez) begin
      errors++;
      $display("FAIL R8 w4 a=%h b=%h ctl=%b zero=%b expected=%b", a, b, c, z4, ez);
    end
  endtask

  initial begin
    logic [31:0] lfsr_a, lfsr_b;
    logic [31:0] corners [8];
    a32 = '0; b32 = '0; c32 = '0;
    a4 = '0; b4 = '0; c4 = '0;
    // Initial state: all-zero inputs give zero result and zero flag set (R8)
    apply32(32'd0, 32'd0, 4'b0000);
    // Directed R5 case without overflow correction: expect 1
    apply32(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
    // R4 equal operands: zero and carry_out both 1
    apply32(32'h1234_5678, 32'h1234_5678, 4'b0110);
    // R3 signed overflow
    apply32(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);
    // Exhaustive 4-bit sweep over all codes (R1..R10)
    for (int c = 0; c < 16; c++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply4(4'(a), 4'(b), 4'(c));
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'hFFFF_FFFF; corners[5] = 32'h8000_0001;
    corners[6] = 32'h5555_5555; corners[7] = 32'hAAAA_AAAA;
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          apply32(corners[i], corners[j], 4'(c));
    end
    lfsr_a = 32'hACE1_2345;
    lfsr_b = 32'h1357_9BDF;
    for (int n = 0; n < 2000; n++) begin
      lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
      lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
      apply32(lfsr_a, lfsr_b, 4'(n % 16));
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule